// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block runs one programmed-I/O transfer on a parallel ATA (IDE) cable. A host-side controller gives it a one-cycle start request with a direction, a three-bit device register address, a choice between the command and control register blocks, 16-bit write data and four phase durations. The engine then drives the address and chip-select pins, pulses the read or write strobe, holds write data after the strobe, waits out a recovery interval, and reports completion with a single-clock done pulse. On reads it keeps the word sampled from the data bus as the strobe rises.

Each phase is timed by one down-counter that is loaded at phase entry. A phase lasts its programmed count plus one clock, so a count of zero gives the shortest one-clock phase. The four durations are sampled when a cycle is accepted, and later changes at the inputs leave a running cycle untouched. The device can stretch the strobe by holding its ready line low. That line goes through a two-flop synchroniser before the sequencer looks at it.

Phases run in this order: address setup, strobe, write hold (writes only), recovery. With a 100 MHz clock, the mode 0 setting is setup 6, strobe 28, hold 2 and recovery 23. The reset is asynchronous, and its active level is a parameter.

Top module: `pio_cycle_engine`

## Requirements
- R1: While reset is active, and in the first clock after it, both chip selects and both strobes are high (inactive), the data output enable is 0 and done is 0. Asserting reset in the middle of a cycle returns these pins to that state at once.
- R2: After a start is accepted, address setup lasts t1+1 clocks. In that time the selected chip select is low, da_o equals the requested address, and both strobes are high.
- R3: The strobe phase lasts t2+1 clocks when the device is ready. A read asserts only dior_n_o (low) and a write asserts only diow_n_o (low). The two strobes are never low together.
- R4: A write keeps dd_oe_o high and dd_o equal to the write data from the first setup clock through the end of the hold phase. The hold phase lasts t4+1 clocks after diow_n_o rises. A read never raises dd_oe_o.
- R5: The recovery phase lasts teoc+1 clocks with the chip select still low and both strobes high. done_o is high for exactly one clock, the last recovery clock. After it, both chip selects go high.
- R6: A read captures dd_i on the clock edge where dior_n_o rises. rdata_o then holds that word until the next read completes, and a write leaves it unchanged.
- R7: ctrl_sel_i = 1 selects the control block (cs1_n_o low, cs0_n_o high). ctrl_sel_i = 0 selects the command block (cs0_n_o low, cs1_n_o high). da_o equals reg_addr_i. Address and select stay stable for the whole cycle.
- R8: While the synchronised ready line is low in the last strobe clock, the strobe stays asserted. The strobe rises on the third rising clock edge after iordy_i goes high.
- R9: The timing values, address, select, direction and write data are sampled when the start is accepted. Changing them later does not alter the running cycle.
- R10: A start request that arrives while a cycle is in progress is ignored. It neither disturbs the running cycle nor starts a second one.
- R11: Timing counts of zero give a cycle of one clock per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_i | input | 1 | Asynchronous reset, active at level RST_LVL |
| start_i | input | 1 | One-clock request to begin a cycle; honoured only when idle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ctrl_sel_i | input | 1 | 1 = control block (cs1), 0 = command block (cs0) |
| reg_addr_i | input | 3 | Device register address driven onto da_o |
| wdata_i | input | 16 | Write data |
| t1_i | input | CNT_W | Address setup count |
| t2_i | input | CNT_W | Strobe width count |
| t4_i | input | CNT_W | Write hold count |
| teoc_i | input | CNT_W | Recovery count |
| iordy_i | input | 1 | Device ready, asynchronous |
| dd_i | input | 16 | Data bus from device |
| dd_o | output | 16 | Data bus toward device |
| dd_oe_o | output | 1 | Output enable for dd_o |
| da_o | output | 3 | Device address pins |
| cs0_n_o | output | 1 | Command block select, active low |
| cs1_n_o | output | 1 | Control block select, active low |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | 16 | Last captured read word |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A sequencer stuck in the wrong phase, or a counter loaded from the wrong timing register, shows up in the very cycle it happens. One phase comes out a different number of clocks long, so the bench measures each phase length at the pins, cycle by cycle, against the programmed counts. A wrong direction or a stale latch shows up as the wrong strobe, a data enable during a read, or a moved address inside the cycle. A bad capture point, or a synchroniser with the wrong depth, shows up only when the cycle ends: rdata_o holds the wrong word, or the stretched strobe rises one clock early or late.

// File: rtl/pio_engine_pkg.sv
package pio_engine_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RECOVER = 3'd4
  } pio_phase_e;

  // Phase order: setup -> strobe -> (hold, writes only) -> recover -> idle.
  function automatic pio_phase_e pio_next_phase(
    input pio_phase_e cur,
    input logic       start,
    input logic       cnt_zero,
    input logic       ready,
    input logic       is_write
  );
    pio_phase_e nxt;
    nxt = cur;
    case (cur)
      PH_IDLE:    if (start) nxt = PH_SETUP;
      PH_SETUP:   if (cnt_zero) nxt = PH_STROBE;
      PH_STROBE:  if (cnt_zero && ready) nxt = is_write ? PH_HOLD : PH_RECOVER;
      PH_HOLD:    if (cnt_zero) nxt = PH_RECOVER;
      PH_RECOVER: if (cnt_zero) nxt = PH_IDLE;
      default:    nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // True in phases where the data bus is driven for a write.
  function automatic logic pio_drive_phase(input pio_phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

  // Number of clocks a phase lasts for a loaded count.
  function automatic int unsigned pio_phase_clocks(input int unsigned count);
    return count + 1;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= {STAGES{RESET_VAL}};
    else          chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio_phase_counter.sv
module pio_phase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pio_sequencer.sv
module pio_sequencer
  import pio_engine_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       start_i,
  input  logic       wr_i,
  input  logic       cnt_zero_i,
  input  logic       ready_i,
  output pio_phase_e phase_o,
  output pio_phase_e next_o,
  output logic       accept_o,
  output logic       load_o
);
  pio_phase_e phase_q;
  pio_phase_e phase_d;

  always_comb begin
    phase_d = pio_next_phase(phase_q, start_i, cnt_zero_i, ready_i, wr_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) phase_q <= PH_IDLE;
    else          phase_q <= phase_d;
  end

  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign load_o   = (phase_d != phase_q) && (phase_d != PH_IDLE);
  assign phase_o  = phase_q;
  assign next_o   = phase_d;
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_engine_pkg::*;
#(
  parameter int   CNT_W       = 8,
  parameter logic RST_LVL     = 1'b0,
  parameter int   SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             arst_i,
  input  logic             start_i,
  input  logic             write_i,
  input  logic             ctrl_sel_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [CNT_W-1:0] t4_i,
  input  logic [CNT_W-1:0] teoc_i,
  input  logic             iordy_i,
  input  logic [15:0]      dd_i,
  output logic [15:0]      dd_o,
  output logic             dd_oe_o,
  output logic [2:0]       da_o,
  output logic             cs0_n_o,
  output logic             cs1_n_o,
  output logic             dior_n_o,
  output logic             diow_n_o,
  output logic [15:0]      rdata_o,
  output logic             done_o
);
  // Reset normalised to active low for every register.
  logic rst_act;
  logic rst_n;
  assign rst_act = (arst_i == RST_LVL);
  assign rst_n   = !rst_act;

  // Named internal events (observed by the checker).
  pio_phase_e phase;
  pio_phase_e phase_nxt;
  logic       accept;
  logic       load;
  logic       cnt_zero;
  logic       iordy_ok;
  logic       strobe_end;
  logic       cyc_active;

  // Values captured at accept.
  logic             wr_q;
  logic             sel_q;
  logic [2:0]       addr_q;
  logic [15:0]      wdata_q;
  logic [CNT_W-1:0] t2_q;
  logic [CNT_W-1:0] t4_q;
  logic [CNT_W-1:0] teoc_q;
  logic [CNT_W-1:0] load_val;
  logic [15:0]      rdata_q;

  pio_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_iordy_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n),
    .d_i    (iordy_i),
    .q_o    (iordy_ok)
  );

  pio_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .start_i   (start_i),
    .wr_i      (wr_q),
    .cnt_zero_i(cnt_zero),
    .ready_i   (iordy_ok),
    .phase_o   (phase),
    .next_o    (phase_nxt),
    .accept_o  (accept),
    .load_o    (load)
  );

  // The setup count is taken straight from the input at accept; the others
  // come from the copies captured at the same edge.
  always_comb begin
    case (phase_nxt)
      PH_SETUP:   load_val = t1_i;
      PH_STROBE:  load_val = t2_q;
      PH_HOLD:    load_val = t4_q;
      PH_RECOVER: load_val = teoc_q;
      default:    load_val = '0;
    endcase
  end

  pio_phase_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      sel_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      t2_q    <= '0;
      t4_q    <= '0;
      teoc_q  <= '0;
    end else if (accept) begin
      wr_q    <= write_i;
      sel_q   <= ctrl_sel_i;
      addr_q  <= reg_addr_i;
      wdata_q <= wdata_i;
      t2_q    <= t2_i;
      t4_q    <= t4_i;
      teoc_q  <= teoc_i;
    end
  end

  // Strobe deasserts at the edge where the strobe phase is left.
  assign strobe_end = (phase == PH_STROBE) && (phase_nxt != PH_STROBE);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (strobe_end && !wr_q) rdata_q <= dd_i;
  end

  assign cyc_active = (phase != PH_IDLE);

  assign da_o     = addr_q;
  assign cs0_n_o  = !(cyc_active && !sel_q);
  assign cs1_n_o  = !(cyc_active && sel_q);
  assign dior_n_o = !((phase == PH_STROBE) && !wr_q);
  assign diow_n_o = !((phase == PH_STROBE) && wr_q);
  assign dd_o     = wdata_q;
  assign dd_oe_o  = wr_q && pio_drive_phase(phase);
  assign rdata_o  = rdata_q;
  assign done_o   = (phase == PH_RECOVER) && cnt_zero;

endmodule

// File: rtl/pio_engine_chk.sv
module pio_engine_chk (
  input logic       clk,
  input logic       rst_act,
  input logic       cs0_n,
  input logic       cs1_n,
  input logic       dior_n,
  input logic       diow_n,
  input logic       dd_oe,
  input logic [2:0] da,
  input logic       done,
  input logic       strobe_end,
  input logic       iordy_ok
);
  logic cs_any;
  assign cs_any = !cs0_n || !cs1_n;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst_act)
    !(!dior_n && !diow_n));

  // R7
  cs_excl_chk: assert property (@(posedge clk) disable iff (rst_act)
    !(!cs0_n && !cs1_n));

  // R4
  oe_write_only_chk: assert property (@(posedge clk) disable iff (rst_act)
    dd_oe |-> (dior_n && cs_any));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst_act)
    cs_any |=> (!cs_any || $stable(da)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst_act)
    done |=> !done);

  // R5
  done_in_cycle_chk: assert property (@(posedge clk) disable iff (rst_act)
    done |-> (cs_any && dior_n && diow_n));

  // R2
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst_act)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(cs_any));

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst_act)
    strobe_end |-> iordy_ok);
endmodule

bind pio_cycle_engine pio_engine_chk u_chk (
  .clk       (clk_i),
  .rst_act   (rst_act),
  .cs0_n     (cs0_n_o),
  .cs1_n     (cs1_n_o),
  .dior_n    (dior_n_o),
  .diow_n    (diow_n_o),
  .dd_oe     (dd_oe_o),
  .da        (da_o),
  .done      (done_o),
  .strobe_end(strobe_end),
  .iordy_ok  (iordy_ok)
);

// File: tb/tb_pio_cycle_engine.sv
module tb_pio_cycle_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  typedef struct packed {
    logic        wr;
    logic        sel;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] ddin;
    logic [7:0]  t1;
    logic [7:0]  t2;
    logic [7:0]  t4;
    logic [7:0]  teoc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 3'd7, 16'h0000, 16'hBEEF, 8'd6, 8'd28, 8'd2, 8'd23},
    '{1'b1, 1'b1, 3'd6, 16'hA5C3, 16'h1111, 8'd6, 8'd28, 8'd2, 8'd23},
    '{1'b1, 1'b0, 3'd1, 16'h3C5A, 16'h2222, 8'd1, 8'd3,  8'd0, 8'd2},
    '{1'b0, 1'b1, 3'd4, 16'h0000, 16'h8001, 8'd0, 8'd0,  8'd0, 8'd0},
    '{1'b1, 1'b0, 3'd2, 16'hFFFF, 16'h3333, 8'd0, 8'd0,  8'd0, 8'd0},
    '{1'b0, 1'b1, 3'd0, 16'h0000, 16'h7E18, 8'd3, 8'd5,  8'd4, 8'd1}
  };

  logic          clk = 1'b0;
  logic          arst = 1'b0;
  logic          start = 1'b0;
  logic          write = 1'b0;
  logic          ctrl_sel = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   wdata = '0;
  logic [CW-1:0] t1 = '0, t2 = '0, t4 = '0, teoc = '0;
  logic          iordy = 1'b1;
  logic [15:0]   dd_in = '0;
  logic [15:0]   dd_out;
  logic          dd_oe;
  logic [2:0]    da;
  logic          cs0_n, cs1_n, dior_n, diow_n, done;
  logic [15:0]   rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_engine #(.CNT_W(CW), .RST_LVL(1'b0), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .arst_i(arst), .start_i(start), .write_i(write),
    .ctrl_sel_i(ctrl_sel), .reg_addr_i(reg_addr), .wdata_i(wdata),
    .t1_i(t1), .t2_i(t2), .t4_i(t4), .teoc_i(teoc), .iordy_i(iordy),
    .dd_i(dd_in), .dd_o(dd_out), .dd_oe_o(dd_oe), .da_o(da),
    .cs0_n_o(cs0_n), .cs1_n_o(cs1_n), .dior_n_o(dior_n), .diow_n_o(diow_n),
    .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idle_pins();
    return (cs0_n && cs1_n && dior_n && diow_n && !dd_oe && !done) ? 1 : 0;
  endfunction

  task automatic issue(input vec_t v);
    @(negedge clk);
    write = v.wr; ctrl_sel = v.sel; reg_addr = v.addr; wdata = v.wdata;
    t1 = v.t1; t2 = v.t2; t4 = v.t4; teoc = v.teoc; dd_in = v.ddin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble every sampled input once the cycle has been accepted
    write = ~v.wr; ctrl_sel = ~v.sel; reg_addr = ~v.addr; wdata = ~v.wdata;
    t1 = 8'hFF; t2 = 8'hFF; t4 = 8'hFF; teoc = 8'hFF;
  endtask

  task automatic run_vec(input vec_t v);
    int setup_c = 0, strobe_c = 0, hold_c = 0, rec_c = 0;
    int done_c = 0, done_at = -1, cs_c = 0, wrong_c = 0, sel_bad = 0, dd_bad = 0;
    bit seen = 0;
    logic [15:0] rd_before;
    rd_before = rdata;
    issue(v);
    for (int k = 0; k < 2000; k++) begin
      if (cs0_n && cs1_n) break;
      cs_c++;
      if (done) begin done_c++; done_at = cs_c; end
      if (da != v.addr || cs1_n != !v.sel || cs0_n != v.sel) sel_bad++;
      if (v.wr ? !dior_n : !diow_n) wrong_c++;
      if (!v.wr && dd_oe) dd_bad++;
      if (v.wr ? !diow_n : !dior_n) begin
        strobe_c++; seen = 1;
        if (v.wr && (!dd_oe || dd_out != v.wdata)) dd_bad++;
      end else if (!seen) begin
        setup_c++;
        if (dd_oe != v.wr) dd_bad++;
        if (v.wr && dd_out != v.wdata) dd_bad++;
      end else if (dd_oe) begin
        hold_c++;
        if (dd_out != v.wdata) dd_bad++;
      end else begin
        rec_c++;
      end
      @(negedge clk);
    end
    chk("R2 setup clocks", setup_c, v.t1 + 1);
    chk("R3 strobe clocks", strobe_c, v.t2 + 1);
    chk("R3 wrong strobe", wrong_c, 0);
    chk("R4 hold clocks", hold_c, v.wr ? v.t4 + 1 : 0);
    chk("R4 data drive", dd_bad, 0);
    chk("R5 recovery clocks", rec_c, v.teoc + 1);
    chk("R5 done count", done_c, 1);
    chk("R5 done position", done_at, cs_c);
    chk("R7 addr/select", sel_bad, 0);
    dd_in = 16'h0F0F;
    @(negedge clk);
    chk("R6 read word", rdata, v.wr ? rd_before : v.ddin);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: pins idle while reset is held
    chk("R1 idle in reset", idle_pins(), 1);
    arst = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", idle_pins(), 1);
    chk("R6 read word reset", rdata, 0);

    // Table walk: R2..R7, R9, R11 (vectors 3 and 4 use zero counts)
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R8: stretched strobe
    begin
      vec_t v;
      int low_c = 0, after_c = 0;
      v = '{1'b0, 1'b0, 3'd3, 16'h0, 16'h5AA5, 8'd2, 8'd3, 8'd1, 8'd2};
      iordy = 1'b0;
      issue(v);
      for (int k = 0; k < 50 && dior_n; k++) @(negedge clk);
      for (int k = 0; k < 12; k++) begin
        if (!dior_n) low_c++;
        if (k < 11) @(negedge clk);
      end
      chk("R8 held while not ready", low_c, 12);
      iordy = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 10 && !dior_n; k++) begin
        after_c++;
        @(negedge clk);
      end
      chk("R8 release latency", after_c, 2);
      for (int k = 0; k < 50 && !(cs0_n && cs1_n); k++) @(negedge clk);
      chk("R8 stretched read word", rdata, 16'h5AA5);
    end

    // R10: start while busy is ignored
    begin
      vec_t v;
      int moved = 0, cs1_c = 0, extra = 0;
      v = '{1'b1, 1'b0, 3'd2, 16'h1234, 16'h0, 8'd4, 8'd4, 8'd1, 8'd4};
      issue(v);
      @(negedge clk);
      write = 1'b0; ctrl_sel = 1'b1; reg_addr = 3'd5; t1 = 8'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 100 && !(cs0_n && cs1_n); k++) begin
        if (da != 3'd2) moved++;
        if (!cs1_n) cs1_c++;
        @(negedge clk);
      end
      chk("R10 address undisturbed", moved, 0);
      chk("R10 select undisturbed", cs1_c, 0);
      for (int k = 0; k < 10; k++) begin
        if (!(cs0_n && cs1_n)) extra++;
        @(negedge clk);
      end
      chk("R10 no second cycle", extra, 0);
    end

    // R1: reset in the middle of a strobe
    begin
      vec_t v;
      v = '{1'b1, 1'b1, 3'd6, 16'hCAFE, 16'h0, 8'd1, 8'd10, 8'd1, 8'd1};
      issue(v);
      for (int k = 0; k < 20 && diow_n; k++) @(negedge clk);
      arst = 1'b0;
      #1;
      chk("R1 mid-cycle reset", idle_pins(), 1);
      @(negedge clk);
      arst = 1'b1;
      @(negedge clk);
      chk("R1 idle after mid reset", idle_pins(), 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule